// File: doc/BRIEF.md
# Flash Program/Erase Status Reporter

This block models the status side of a parallel NOR flash in synchronous form. A command decoder upstream turns bus write sequences into single-cycle strobes: program, sector erase, chip erase, erase suspend, erase resume and identification request. Each strobe stands for the final write pulse of its sequence. The block keeps track of which embedded operation is running. It stands in for the cell work with down-counters whose lengths are parameters.

While an operation runs, a read that targets the affected sector returns a status value on data bit 7 in place of array data. A program operation reports the complement of the bit it is writing. An erase reports zero until it completes. Reads of other sectors, and all reads once the operation has ended, pass the array's bit 7 through unchanged.

A ready/busy line is modelled as an open-drain pull-down enable. It is asserted while programming or erasing, and released while idle or while an erase is suspended. A sector erase can be suspended and resumed. The remaining time is kept across the pause. A program may be started while the erase is suspended.

Top module: `flash_status_unit`

## Requirements
- R1: During reset and after it, the block is idle: `rb_pull_en` is 0, `status_sel` is 0, `id_accept` is 0, and `dq7_out` equals `array_d7`.
- R2: From the cycle after a program strobe, a read (`rd_en`=1) whose `rd_sector` equals the programmed sector gives `status_sel`=1 and `dq7_out` = NOT of the latched `ev_data7`. Once the operation has finished, the same read gives `status_sel`=0 and `dq7_out`=`array_d7`.
- R3: While a sector erase runs, a read of the erased sector gives `status_sel`=1 and `dq7_out`=0. While a chip erase runs, a read of any sector gives the same. After completion, reads pass `array_d7` through.
- R4: Status and busy take effect in the first cycle after the strobe. `rb_pull_en` then stays high for exactly PROG_CYC cycles for a program, SERASE_CYC cycles for a sector erase and CERASE_CYC cycles for a chip erase, counting only cycles that are not suspended.
- R5: A read of a sector other than the one being operated on, or a cycle with `rd_en`=0, gives `status_sel`=0 and `dq7_out`=`array_d7`.
- R6: `rb_pull_en` is 1 while a program, an erase, or a program started during suspend is running. It is 0 while idle or while an erase is suspended.
- R7: A suspend strobe during a running sector erase moves the block to suspended and freezes the remaining count. A resume strobe continues the erase from that count. A resume strobe while the erase is already running is ignored. A later suspend strobe is accepted again.
- R8: Suspend and resume strobes have no effect while idle, while a program runs outside suspend, or while a chip erase runs.
- R9: While suspended, a program strobe starts a program that lasts PROG_CYC cycles and then returns to suspended. In that state a read of the programmed sector reports NOT of the written bit. In both suspended states, a read of the suspended sector reports `dq7_out`=0 with `status_sel`=1.
- R10: `id_accept` is high in the same cycle as `ev_autoselect` only when the block is idle. It stays 0 during suspend and during any busy state.
- R11: Program and erase strobes that arrive while an operation is running do not start a new operation and do not lengthen the current one. In idle the priority is program, then sector erase, then chip erase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ev_program | input | 1 | Program command strobe |
| ev_sector_erase | input | 1 | Sector erase command strobe |
| ev_chip_erase | input | 1 | Chip erase command strobe |
| ev_suspend | input | 1 | Erase suspend strobe |
| ev_resume | input | 1 | Erase resume strobe |
| ev_autoselect | input | 1 | Identification request strobe |
| ev_sector | input | SECT_W | Sector addressed by the command |
| ev_data7 | input | 1 | Bit 7 of the data being programmed |
| rd_en | input | 1 | Read cycle in progress |
| rd_sector | input | SECT_W | Sector of the read address |
| array_d7 | input | 1 | Bit 7 from the memory array |
| dq7_out | output | 1 | Bit 7 returned to the bus |
| status_sel | output | 1 | High when bit 7 carries status, not array data |
| rb_pull_en | output | 1 | Pull-down enable of the open-drain ready/busy line |
| id_accept | output | 1 | Identification request accepted |

## Verification
The bench tries programs with both polarities of the written bit. This separates a correct inversion from a pass-through or a constant. It tries sector erase and chip erase, polling both the target sector and other sectors, which separates sector matching from global status. A suspend, resume, re-suspend sequence with a program inside the pause checks that the erase time is frozen and not restarted or lost. Stray strobes sent while idle, programming or chip-erasing check that each command is accepted only in the states where it applies.

// File: rtl/fsu_pkg.sv
package fsu_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_PROG  = 3'd1,
    ST_ERASE = 3'd2,
    ST_SUSP  = 3'd3,
    ST_SPROG = 3'd4
  } fsu_state_e;
endpackage

// File: rtl/fsu_op_timer.sv
module fsu_op_timer #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         run,
  output logic         done,
  output logic [W-1:0] count
);
  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load) begin
      cnt_d = load_val;
    end else if (run && (cnt_q != '0)) begin
      cnt_d = cnt_q - W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load || run) begin
      cnt_q <= cnt_d;
    end
  end

  assign done  = run && (cnt_q == W'(1));
  assign count = cnt_q;
endmodule

// File: rtl/fsu_ctrl.sv
module fsu_ctrl
  import fsu_pkg::*;
#(
  parameter int SW         = 6,
  parameter int PW         = 3,
  parameter int EW         = 6,
  parameter int PROG_CYC   = 6,
  parameter int SERASE_CYC = 20,
  parameter int CERASE_CYC = 40
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ev_program,
  input  logic          ev_sector_erase,
  input  logic          ev_chip_erase,
  input  logic          ev_suspend,
  input  logic          ev_resume,
  input  logic          ev_autoselect,
  input  logic [SW-1:0] ev_sector,
  input  logic          ev_data7,
  input  logic          prog_done,
  input  logic          erase_done,
  output fsu_state_e    state,
  output logic          prog_load,
  output logic [PW-1:0] prog_load_val,
  output logic          prog_run,
  output logic          erase_load,
  output logic [EW-1:0] erase_load_val,
  output logic          erase_run,
  output logic [SW-1:0] prog_sector,
  output logic [SW-1:0] erase_sector,
  output logic          chip_flag,
  output logic          prog_d7,
  output logic          id_accept
);
  fsu_state_e    st_q, st_d;
  logic [SW-1:0] psec_q, psec_d, esec_q, esec_d;
  logic          chip_q, chip_d, pd7_q, pd7_d;

  always_comb begin
    st_d           = st_q;
    psec_d         = psec_q;
    esec_d         = esec_q;
    chip_d         = chip_q;
    pd7_d          = pd7_q;
    prog_load      = 1'b0;
    erase_load     = 1'b0;
    erase_load_val = EW'(SERASE_CYC);
    case (st_q)
      ST_IDLE: begin
        if (ev_program) begin
          st_d      = ST_PROG;
          prog_load = 1'b1;
          psec_d    = ev_sector;
          pd7_d     = ev_data7;
        end else if (ev_sector_erase) begin
          st_d       = ST_ERASE;
          erase_load = 1'b1;
          esec_d     = ev_sector;
          chip_d     = 1'b0;
        end else if (ev_chip_erase) begin
          st_d           = ST_ERASE;
          erase_load     = 1'b1;
          erase_load_val = EW'(CERASE_CYC);
          chip_d         = 1'b1;
        end
      end
      ST_PROG: begin
        if (prog_done) st_d = ST_IDLE;
      end
      ST_ERASE: begin
        if (erase_done) begin
          st_d = ST_IDLE;
        end else if (ev_suspend && !chip_q) begin
          st_d = ST_SUSP;
        end
      end
      ST_SUSP: begin
        if (ev_resume) begin
          st_d = ST_ERASE;
        end else if (ev_program) begin
          st_d      = ST_SPROG;
          prog_load = 1'b1;
          psec_d    = ev_sector;
          pd7_d     = ev_data7;
        end
      end
      ST_SPROG: begin
        if (prog_done) st_d = ST_SUSP;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      psec_q <= '0;
      esec_q <= '0;
      chip_q <= 1'b0;
      pd7_q  <= 1'b0;
    end else begin
      st_q <= st_d;
      if (prog_load) begin
        psec_q <= psec_d;
        pd7_q  <= pd7_d;
      end
      if (erase_load) begin
        esec_q <= esec_d;
        chip_q <= chip_d;
      end
    end
  end

  assign state         = st_q;
  assign prog_load_val = PW'(PROG_CYC);
  assign prog_run      = (st_q == ST_PROG) || (st_q == ST_SPROG);
  assign erase_run     = (st_q == ST_ERASE);
  assign prog_sector   = psec_q;
  assign erase_sector  = esec_q;
  assign chip_flag     = chip_q;
  assign prog_d7       = pd7_q;
  assign id_accept     = ev_autoselect && (st_q == ST_IDLE);
endmodule

// File: rtl/fsu_read_mux.sv
module fsu_read_mux
  import fsu_pkg::*;
#(
  parameter int SW = 6
) (
  input  fsu_state_e    state,
  input  logic          rd_en,
  input  logic [SW-1:0] rd_sector,
  input  logic [SW-1:0] prog_sector,
  input  logic [SW-1:0] erase_sector,
  input  logic          chip_flag,
  input  logic          prog_d7,
  input  logic          array_d7,
  output logic          status_sel,
  output logic          dq7_out
);
  logic hit_prog, hit_erase;

  assign hit_prog  = (rd_sector == prog_sector);
  assign hit_erase = (rd_sector == erase_sector);

  always_comb begin
    status_sel = 1'b0;
    dq7_out    = array_d7;
    if (rd_en) begin
      case (state)
        ST_PROG: begin
          if (hit_prog) begin
            status_sel = 1'b1;
            dq7_out    = ~prog_d7;
          end
        end
        ST_ERASE: begin
          if (chip_flag || hit_erase) begin
            status_sel = 1'b1;
            dq7_out    = 1'b0;
          end
        end
        ST_SUSP: begin
          if (hit_erase) begin
            status_sel = 1'b1;
            dq7_out    = 1'b0;
          end
        end
        ST_SPROG: begin
          if (hit_prog) begin
            status_sel = 1'b1;
            dq7_out    = ~prog_d7;
          end else if (hit_erase) begin
            status_sel = 1'b1;
            dq7_out    = 1'b0;
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/flash_status_unit.sv
module flash_status_unit
  import fsu_pkg::*;
#(
  parameter int SECT_W     = 6,
  parameter int PROG_CYC   = 6,
  parameter int SERASE_CYC = 20,
  parameter int CERASE_CYC = 40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_program,
  input  logic              ev_sector_erase,
  input  logic              ev_chip_erase,
  input  logic              ev_suspend,
  input  logic              ev_resume,
  input  logic              ev_autoselect,
  input  logic [SECT_W-1:0] ev_sector,
  input  logic              ev_data7,
  input  logic              rd_en,
  input  logic [SECT_W-1:0] rd_sector,
  input  logic              array_d7,
  output logic              dq7_out,
  output logic              status_sel,
  output logic              rb_pull_en,
  output logic              id_accept
);
  localparam int ERASE_MAX = (SERASE_CYC > CERASE_CYC) ? SERASE_CYC : CERASE_CYC;
  localparam int PROG_W    = $clog2(PROG_CYC + 1);
  localparam int ERASE_W   = $clog2(ERASE_MAX + 1);

  logic [1:0] rst_pipe;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  fsu_state_e         state;
  logic               prog_load, prog_run, prog_done;
  logic               erase_load, erase_run, erase_done;
  logic [PROG_W-1:0]  prog_load_val, prog_count;
  logic [ERASE_W-1:0] erase_load_val, erase_count;
  logic [SECT_W-1:0]  prog_sector, erase_sector;
  logic               chip_flag, prog_d7;

  fsu_ctrl #(
    .SW(SECT_W), .PW(PROG_W), .EW(ERASE_W),
    .PROG_CYC(PROG_CYC), .SERASE_CYC(SERASE_CYC), .CERASE_CYC(CERASE_CYC)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_sync_n),
    .ev_program(ev_program), .ev_sector_erase(ev_sector_erase),
    .ev_chip_erase(ev_chip_erase), .ev_suspend(ev_suspend),
    .ev_resume(ev_resume), .ev_autoselect(ev_autoselect),
    .ev_sector(ev_sector), .ev_data7(ev_data7),
    .prog_done(prog_done), .erase_done(erase_done),
    .state(state),
    .prog_load(prog_load), .prog_load_val(prog_load_val), .prog_run(prog_run),
    .erase_load(erase_load), .erase_load_val(erase_load_val), .erase_run(erase_run),
    .prog_sector(prog_sector), .erase_sector(erase_sector),
    .chip_flag(chip_flag), .prog_d7(prog_d7), .id_accept(id_accept)
  );

  fsu_op_timer #(.W(PROG_W)) u_prog_tmr (
    .clk(clk), .rst_n(rst_sync_n), .load(prog_load), .load_val(prog_load_val),
    .run(prog_run), .done(prog_done), .count(prog_count)
  );

  fsu_op_timer #(.W(ERASE_W)) u_erase_tmr (
    .clk(clk), .rst_n(rst_sync_n), .load(erase_load), .load_val(erase_load_val),
    .run(erase_run), .done(erase_done), .count(erase_count)
  );

  fsu_read_mux #(.SW(SECT_W)) u_rd (
    .state(state), .rd_en(rd_en), .rd_sector(rd_sector),
    .prog_sector(prog_sector), .erase_sector(erase_sector),
    .chip_flag(chip_flag), .prog_d7(prog_d7), .array_d7(array_d7),
    .status_sel(status_sel), .dq7_out(dq7_out)
  );

  assign rb_pull_en = (state == ST_PROG) || (state == ST_ERASE) || (state == ST_SPROG);
endmodule

// File: rtl/fsu_checker.sv
module fsu_checker
  import fsu_pkg::*;
#(
  parameter int SW = 6,
  parameter int EW = 6
) (
  input logic          clk,
  input logic          rst_n,
  input fsu_state_e    state,
  input logic          ev_program,
  input logic          ev_sector_erase,
  input logic          ev_chip_erase,
  input logic          ev_suspend,
  input logic          rd_en,
  input logic [SW-1:0] rd_sector,
  input logic [SW-1:0] prog_sector,
  input logic          prog_d7,
  input logic [EW-1:0] erase_count,
  input logic          dq7_out,
  input logic          status_sel,
  input logic          rb_pull_en,
  input logic          id_accept
);
  AST_PROG_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && ev_program) |=> (rb_pull_en && state == ST_PROG)); // R4
  AST_PROG_POLL: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_PROG && status_sel) |-> (dq7_out == ~prog_d7)); // R2
  AST_ERASE_POLL: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_ERASE && status_sel) |-> !dq7_out); // R3
  AST_FOREIGN_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && state == ST_PROG && rd_sector != prog_sector) |-> !status_sel); // R5
  AST_SUSP_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SUSP) |-> !rb_pull_en); // R6
  AST_SUSP_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SUSP) |=> (state != ST_SUSP || $stable(erase_count))); // R7
  AST_IDLE_SUSP_IGN: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && ev_suspend && !ev_program && !ev_sector_erase && !ev_chip_erase)
      |=> (state == ST_IDLE)); // R8
  AST_ID_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SUSP || state == ST_SPROG) |-> !id_accept); // R10
endmodule

bind flash_status_unit fsu_checker #(.SW(SECT_W), .EW(ERASE_W)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .state(state),
  .ev_program(ev_program), .ev_sector_erase(ev_sector_erase),
  .ev_chip_erase(ev_chip_erase), .ev_suspend(ev_suspend),
  .rd_en(rd_en), .rd_sector(rd_sector), .prog_sector(prog_sector),
  .prog_d7(prog_d7), .erase_count(erase_count), .dq7_out(dq7_out),
  .status_sel(status_sel), .rb_pull_en(rb_pull_en), .id_accept(id_accept)
);

// File: tb/sim_flash_status_unit.sv
`timescale 1ns/1ps
module sim_flash_status_unit;
  localparam int SW = 6;
  localparam int PC = 6;
  localparam int SC = 20;
  localparam int CC = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ev_program = 0, ev_sector_erase = 0, ev_chip_erase = 0;
  logic ev_suspend = 0, ev_resume = 0, ev_autoselect = 0;
  logic [SW-1:0] ev_sector = '0, rd_sector = '0;
  logic ev_data7 = 0, rd_en = 0, array_d7 = 0;
  logic dq7_out, status_sel, rb_pull_en, id_accept;

  always #4 clk = ~clk;

  flash_status_unit #(.SECT_W(SW), .PROG_CYC(PC), .SERASE_CYC(SC), .CERASE_CYC(CC)) u0 (
    .clk(clk), .rst_n(rst_n),
    .ev_program(ev_program), .ev_sector_erase(ev_sector_erase),
    .ev_chip_erase(ev_chip_erase), .ev_suspend(ev_suspend),
    .ev_resume(ev_resume), .ev_autoselect(ev_autoselect),
    .ev_sector(ev_sector), .ev_data7(ev_data7),
    .rd_en(rd_en), .rd_sector(rd_sector), .array_d7(array_d7),
    .dq7_out(dq7_out), .status_sel(status_sel),
    .rb_pull_en(rb_pull_en), .id_accept(id_accept)
  );

  int n_tests = 0, n_fail = 0, busy_cnt = 0;
  bit done_flag = 0;
  string scen = "R1";

  // reference model: 0 idle, 1 program, 2 erase, 3 suspended, 4 program in suspend
  int m_st = 0, m_rp = 0, m_re = 0, m_ps = 0, m_es = 0, m_ch = 0, m_pd = 0;

  task automatic check(input string tag, input string what, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic compare();
    int e_sel, e_d, e_rb, e_id;
    e_sel = 0; e_d = array_d7; e_rb = (m_st == 1 || m_st == 2 || m_st == 4);
    e_id = (ev_autoselect && m_st == 0);
    if (rd_en) begin
      if ((m_st == 1 || m_st == 4) && rd_sector == m_ps) begin e_sel = 1; e_d = !m_pd; end
      else if (m_st == 2 && (m_ch == 1 || rd_sector == m_es)) begin e_sel = 1; e_d = 0; end
      else if ((m_st == 3 || m_st == 4) && rd_sector == m_es) begin e_sel = 1; e_d = 0; end
    end
    check(scen, "status_sel", status_sel, e_sel);
    check(scen, "dq7_out", dq7_out, e_d);
    check("R6", "rb_pull_en", rb_pull_en, e_rb);
    check("R10", "id_accept", id_accept, e_id);
  endtask

  task automatic model_step();
    case (m_st)
      0: if (ev_program) begin m_st = 1; m_rp = PC; m_ps = ev_sector; m_pd = ev_data7; end
         else if (ev_sector_erase) begin m_st = 2; m_re = SC; m_es = ev_sector; m_ch = 0; end
         else if (ev_chip_erase) begin m_st = 2; m_re = CC; m_ch = 1; end
      1: if (m_rp == 1) m_st = 0; else m_rp--;
      2: if (m_re == 1) m_st = 0;
         else begin m_re--; if (ev_suspend && m_ch == 0) m_st = 3; end
      3: if (ev_resume) m_st = 2;
         else if (ev_program) begin m_st = 4; m_rp = PC; m_ps = ev_sector; m_pd = ev_data7; end
      4: if (m_rp == 1) m_st = 3; else m_rp--;
      default: m_st = 0;
    endcase
  endtask

  task automatic tick();
    #1;
    compare();
    if (rb_pull_en) busy_cnt++;
    @(posedge clk);
    model_step();
    @(negedge clk);
    ev_program = 0; ev_sector_erase = 0; ev_chip_erase = 0;
    ev_suspend = 0; ev_resume = 0; ev_autoselect = 0;
    array_d7 = ~array_d7;
  endtask

  task automatic rd(input int sec);
    rd_en = 1; rd_sector = SW'(sec);
  endtask

  task automatic run_ready(input int sec1, input int sec2, output int n);
    n = 0;
    while (rb_pull_en && n < 1000) begin
      rd((n % 2 == 0) ? sec1 : sec2);
      tick();
      n++;
    end
  endtask

  int n;

  initial begin
    @(negedge clk);
    scen = "R1";
    rd(1);
    for (int i = 0; i < 3; i++) tick();
    rst_n = 1'b1;
    for (int i = 0; i < 4; i++) tick();

    // program, written bit 1 then 0
    for (int b = 1; b >= 0; b--) begin
      scen = "R2";
      ev_program = 1; ev_sector = 6'd3; ev_data7 = b[0]; rd(3);
      tick();
      run_ready(3, 3, n);
      check("R4", "program busy cycles", n, PC);
      rd(3); tick(); tick();
    end

    // reads outside the programmed sector
    scen = "R5";
    ev_program = 1; ev_sector = 6'd9; ev_data7 = 1; rd(10);
    tick();
    rd_en = 0; tick();
    run_ready(10, 11, n);
    tick();

    // strobes while busy are ignored
    scen = "R11";
    ev_program = 1; ev_sector = 6'd2; ev_data7 = 0; rd(2);
    tick();
    ev_sector_erase = 1; ev_sector = 6'd4; tick();
    ev_chip_erase = 1; tick();
    ev_program = 1; ev_sector = 6'd5; ev_data7 = 1; tick();
    run_ready(2, 4, n);
    check("R11", "program busy cycles with stray strobes", n + 3, PC);
    rd(4); tick();

    // sector erase and chip erase
    scen = "R3";
    ev_sector_erase = 1; ev_sector = 6'd7; rd(7);
    tick();
    run_ready(7, 8, n);
    check("R4", "sector erase busy cycles", n, SC);
    rd(7); tick();
    ev_chip_erase = 1; rd(20);
    tick();
    run_ready(33, 0, n);
    check("R4", "chip erase busy cycles", n, CC);
    tick();

    // suspend/resume where they do not apply
    scen = "R8";
    ev_suspend = 1; rd(7); tick();
    ev_resume = 1; tick();
    ev_program = 1; ev_sector = 6'd1; ev_data7 = 1; rd(1); tick();
    ev_suspend = 1; tick();
    run_ready(1, 1, n);
    check("R8", "program busy cycles with suspend", n + 1, PC);
    ev_chip_erase = 1; tick();
    ev_suspend = 1; rd(12); tick();
    ev_resume = 1; tick();
    run_ready(12, 13, n);
    check("R8", "chip erase busy cycles with suspend", n + 2, CC);
    tick();

    // suspend, resume, program in suspend
    scen = "R7";
    busy_cnt = 0;
    ev_sector_erase = 1; ev_sector = 6'd5; rd(5);
    tick();
    for (int i = 0; i < 4; i++) tick();
    ev_suspend = 1; tick();
    for (int i = 0; i < 5; i++) begin rd((i % 2 == 0) ? 5 : 6); tick(); end
    ev_autoselect = 1; tick();
    ev_resume = 1; rd(5); tick();
    tick(); tick();
    ev_resume = 1; tick();
    tick();
    ev_suspend = 1; tick();
    scen = "R9";
    ev_program = 1; ev_sector = 6'd11; ev_data7 = 0; rd(11);
    tick();
    ev_autoselect = 1; ev_suspend = 1; tick();
    run_ready(11, 5, n);
    check("R9", "program during suspend busy cycles", n + 1, PC);
    rd(5); tick();
    check("R9", "rb released back in suspend", rb_pull_en, 0);
    scen = "R7";
    ev_resume = 1; tick();
    run_ready(5, 6, n);
    check("R7", "erase plus program busy total", busy_cnt, SC + PC);

    // identification when idle
    scen = "R10";
    ev_autoselect = 1; tick();
    tick();

    if (!done_flag) begin
      done_flag = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    #(8 * 200000);
    if (!done_flag) begin
      done_flag = 1;
      n_tests++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule